// File: doc/BRIEF.md
# Dual-Rate Lane Oversampling Adapter

This block connects a byte-wide link datapath, one byte per lane per clock, to the parallel word port of a serializer/deserializer. In the low-speed rate the serializer runs at twice the needed line rate. On transmit, every data bit is sent twice. On receive, one bit of each duplicated pair is kept. In the high-speed rate the byte passes straight through, and the serializer uses only the lower half of its word.

The block also generates the word for the forwarded-clock lane. This lane never carries duplicated data. In the low-speed rate it sends pairs of ones and zeros that start one bit time late, which puts the clock edges a quarter period away from the data edges. In the high-speed rate it sends a plain alternating pattern, because only the frequency matters there.

The rate is latched only during reset or on a load strobe, so a word is never split between the two rates. A diagnostic flag per lane reports received pairs that disagree. All outputs are registered.

Top module: `ovs_lane_adapter`

## Requirements
- R1: While `rst` is high, all word and byte outputs and all error flags clear to zero at each clock edge, and the active rate is loaded from `rate_req`. `rate_hi` reads 1 for the high-speed rate.
- R2: In the low-speed rate, transmit bit i of a lane goes to serializer word bits 2i and 2i+1.
- R3: In the high-speed rate, the transmit byte appears unchanged in word bits [7:0] of its lane, and bits [15:8] are zero.
- R4: In the low-speed rate, received byte bit i of a lane is taken from deserializer word bit 2i.
- R5: In the high-speed rate, the received byte is word bits [7:0], and word bits [15:8] have no effect on any output.
- R6: In the low-speed rate, a lane's pair error flag is 1 when any pair (bit 2i, bit 2i+1) of its received word differs. The flag does not alter the received byte. In the high-speed rate the flag is 0.
- R7: In the low-speed rate, the forwarded-clock word is 16'h9999. Bit 0 goes first, so the line sees 1,0,0,1,1,0,0,1 and so on.
- R8: In the high-speed rate, the forwarded-clock word is 16'h0055 (alternating 1,0 in bits [7:0], zero above).
- R9: Out of reset, `rate_req` takes effect only at a clock edge where `rate_load` is high. At all other edges, changing `rate_req` leaves the rate and all outputs unaffected.
- R10: Each output reflects the inputs and the rate present at the previous rising clock edge: exactly one cycle of latency. Inputs changed between edges do not alter the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_req | input | 1 | Requested rate, 0 low-speed, 1 high-speed |
| rate_load | input | 1 | Strobe that latches `rate_req` |
| tx_byte | input | LANES*8 | Transmit bytes, lane n at [8n+7:8n] |
| ser_tx_word | output | LANES*16 | Serializer words, lane n at [16n+15:16n] |
| ser_rx_word | input | LANES*16 | Deserializer words, lane n at [16n+15:16n] |
| rx_byte | output | LANES*8 | Recovered bytes |
| rx_pair_err | output | LANES | Per-lane pair disagreement flag |
| fwd_clk_word | output | 16 | Forwarded-clock lane word |
| rate_hi | output | 1 | Active rate, 1 for high-speed |

## Verification
Every data, flag and clock-lane result is due one rising edge after its inputs are applied. `rate_hi` changes one edge after a load strobe, and the word sampled at that same edge still uses the old rate. The bench drives inputs at the falling edge and computes expectations from the rate it models before the edge. It compares the outputs at the next falling edge. Right after driving new inputs, it also confirms that the outputs still hold the previous expectation.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  typedef enum logic {
    RATE_LOW  = 1'b0,
    RATE_HIGH = 1'b1
  } rate_e;
endpackage

// File: rtl/ovs_rate_ctl.sv
module ovs_rate_ctl
  import ovs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rate_req,
  input  logic  rate_load,
  output rate_e rate_o
);
  rate_e rate_q;

  always_ff @(posedge clk) begin
    if (rst || rate_load) rate_q <= rate_e'(rate_req);
  end

  assign rate_o = rate_q;

  // R9
  rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rate_load |=> $stable(rate_q));
endmodule

// File: rtl/ovs_tx_lane.sv
module ovs_tx_lane
  import ovs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  rate_e               rate,
  input  logic [BYTE_W-1:0]   byte_i,
  output logic [2*BYTE_W-1:0] word_o
);
  localparam int SER_W = 2 * BYTE_W;

  logic [SER_W-1:0] dup_w;
  logic [SER_W-1:0] pass_w;
  logic [SER_W-1:0] word_q;
  logic [SER_W-1:0] even_mask;

  always_comb begin
    for (int i = 0; i < BYTE_W; i++) begin
      dup_w[2*i]     = byte_i[i];
      dup_w[2*i+1]   = byte_i[i];
      even_mask[2*i]   = 1'b1;
      even_mask[2*i+1] = 1'b0;
    end
    pass_w = {{BYTE_W{1'b0}}, byte_i};
  end

  always_ff @(posedge clk) begin
    if (rst)                    word_q <= '0;
    else if (rate == RATE_HIGH) word_q <= pass_w;
    else                        word_q <= dup_w;
  end

  assign word_o = word_q;

  // R2
  tx_dup_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == RATE_LOW) |=> (((word_q ^ (word_q >> 1)) & even_mask) == '0));
  // R3
  tx_hs_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == RATE_HIGH) |=> (word_q[SER_W-1:BYTE_W] == '0));
  // R10
  tx_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == RATE_HIGH) |=> (word_q[BYTE_W-1:0] == $past(byte_i)));
endmodule

// File: rtl/ovs_rx_lane.sv
module ovs_rx_lane
  import ovs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  rate_e               rate,
  input  logic [2*BYTE_W-1:0] word_i,
  output logic [BYTE_W-1:0]   byte_o,
  output logic                pair_err_o
);
  logic [BYTE_W-1:0] even_bits;
  logic [BYTE_W-1:0] pair_diff;
  logic [BYTE_W-1:0] byte_q;
  logic              err_q;

  always_comb begin
    for (int i = 0; i < BYTE_W; i++) begin
      even_bits[i] = word_i[2*i];
      pair_diff[i] = word_i[2*i] ^ word_i[2*i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      err_q  <= 1'b0;
    end else if (rate == RATE_HIGH) begin
      byte_q <= word_i[BYTE_W-1:0];
      err_q  <= 1'b0;
    end else begin
      byte_q <= even_bits;
      err_q  <= |pair_diff;
    end
  end

  assign byte_o     = byte_q;
  assign pair_err_o = err_q;

  // R6
  rx_err_hs_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == RATE_HIGH) |=> !err_q);
  // R4
  rx_even_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == RATE_LOW) |=> (byte_q[0] == $past(word_i[0])));
endmodule

// File: rtl/ovs_fwd_clk.sv
module ovs_fwd_clk
  import ovs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  rate_e               rate,
  output logic [2*BYTE_W-1:0] word_o
);
  localparam int SER_W = 2 * BYTE_W;

  logic [SER_W-1:0] pat_low;
  logic [SER_W-1:0] pat_high;
  logic [SER_W-1:0] word_q;

  always_comb begin
    for (int k = 0; k < SER_W; k++) begin
      pat_low[k]  = (((k + 1) / 2) % 2) == 0;
      pat_high[k] = (k < BYTE_W) && ((k % 2) == 0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    word_q <= '0;
    else if (rate == RATE_HIGH) word_q <= pat_high;
    else                        word_q <= pat_low;
  end

  assign word_o = word_q;

  // R7
  clk_low_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == RATE_LOW) |=> (word_q[0] && !word_q[1] && !word_q[2] && word_q[3]));
  // R8
  clk_high_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == RATE_HIGH) |=> (word_q[0] && !word_q[1] && !word_q[SER_W-1]));
endmodule

// File: rtl/ovs_lane_adapter.sv
module ovs_lane_adapter
  import ovs_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rate_req,
  input  logic                      rate_load,
  input  logic [LANES*BYTE_W-1:0]   tx_byte,
  output logic [LANES*2*BYTE_W-1:0] ser_tx_word,
  input  logic [LANES*2*BYTE_W-1:0] ser_rx_word,
  output logic [LANES*BYTE_W-1:0]   rx_byte,
  output logic [LANES-1:0]          rx_pair_err,
  output logic [2*BYTE_W-1:0]       fwd_clk_word,
  output logic                      rate_hi
);
  localparam int SER_W = 2 * BYTE_W;

  rate_e rate;

  ovs_rate_ctl u_rate (
    .clk       (clk),
    .rst       (rst),
    .rate_req  (rate_req),
    .rate_load (rate_load),
    .rate_o    (rate)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    ovs_tx_lane #(.BYTE_W(BYTE_W)) u_tx (
      .clk    (clk),
      .rst    (rst),
      .rate   (rate),
      .byte_i (tx_byte[n*BYTE_W +: BYTE_W]),
      .word_o (ser_tx_word[n*SER_W +: SER_W])
    );
    ovs_rx_lane #(.BYTE_W(BYTE_W)) u_rx (
      .clk        (clk),
      .rst        (rst),
      .rate       (rate),
      .word_i     (ser_rx_word[n*SER_W +: SER_W]),
      .byte_o     (rx_byte[n*BYTE_W +: BYTE_W]),
      .pair_err_o (rx_pair_err[n])
    );
  end

  ovs_fwd_clk #(.BYTE_W(BYTE_W)) u_clk (
    .clk    (clk),
    .rst    (rst),
    .rate   (rate),
    .word_o (fwd_clk_word)
  );

  assign rate_hi = (rate == RATE_HIGH);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (ser_tx_word == '0 && rx_byte == '0 && rx_pair_err == '0));
endmodule

// File: tb/tb_ovs_lane_adapter.sv
`timescale 1ns/100ps
module tb_ovs_lane_adapter;
  localparam int LANES = 2;
  localparam int BW    = 8;
  localparam int SW    = 16;

  logic clk = 0;
  logic rst, rate_req, rate_load;
  logic [LANES*BW-1:0] tx_byte;
  logic [LANES*SW-1:0] ser_tx_word, ser_rx_word;
  logic [LANES*BW-1:0] rx_byte;
  logic [LANES-1:0]    rx_pair_err;
  logic [SW-1:0]       fwd_clk_word;
  logic                rate_hi;

  int checks = 0, fails = 0;
  bit model_hi = 0;
  logic [LANES*SW-1:0] e_tx;
  logic [LANES*BW-1:0] e_rx;
  logic [LANES-1:0]    e_err;
  logic [SW-1:0]       e_clk;

  always #2.5 clk = ~clk;

  ovs_lane_adapter #(.LANES(LANES), .BYTE_W(BW)) dut (
    .clk(clk), .rst(rst), .rate_req(rate_req), .rate_load(rate_load),
    .tx_byte(tx_byte), .ser_tx_word(ser_tx_word), .ser_rx_word(ser_rx_word),
    .rx_byte(rx_byte), .rx_pair_err(rx_pair_err),
    .fwd_clk_word(fwd_clk_word), .rate_hi(rate_hi));

  function automatic logic [SW-1:0] dup(input logic [BW-1:0] b);
    logic [SW-1:0] w;
    for (int i = 0; i < BW; i++) begin w[2*i] = b[i]; w[2*i+1] = b[i]; end
    return w;
  endfunction

  function automatic logic [BW-1:0] evens(input logic [SW-1:0] w);
    logic [BW-1:0] b;
    for (int i = 0; i < BW; i++) b[i] = w[2*i];
    return b;
  endfunction

  function automatic logic perr(input logic [SW-1:0] w);
    logic e = 0;
    for (int i = 0; i < BW; i++) e |= w[2*i] ^ w[2*i+1];
    return e;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compute_exp();
    for (int n = 0; n < LANES; n++) begin
      logic [SW-1:0] rw = ser_rx_word[n*SW +: SW];
      if (model_hi) begin
        e_tx[n*SW +: SW] = {8'h00, tx_byte[n*BW +: BW]};
        e_rx[n*BW +: BW] = rw[BW-1:0];
        e_err[n]         = 1'b0;
      end else begin
        e_tx[n*SW +: SW] = dup(tx_byte[n*BW +: BW]);
        e_rx[n*BW +: BW] = evens(rw);
        e_err[n]         = perr(rw);
      end
    end
    e_clk = model_hi ? 16'h0055 : 16'h9999;
  endtask

  task automatic check_all();
    string tx_tag  = model_hi ? "R3" : "R2";
    string rx_tag  = model_hi ? "R5" : "R4";
    string clk_tag = model_hi ? "R8" : "R7";
    check(tx_tag, ser_tx_word, e_tx);
    check(rx_tag, rx_byte, e_rx);
    check("R6", rx_pair_err, e_err);
    check(clk_tag, fwd_clk_word, e_clk);
    check("R9", rate_hi, model_hi);
  endtask

  // one cycle: inputs applied at falling edge, result checked at the next falling edge
  task automatic cycle(input logic [LANES*BW-1:0] tb, input logic [LANES*SW-1:0] rw,
                       input logic ld, input logic req);
    tx_byte = tb; ser_rx_word = rw; rate_load = ld; rate_req = req;
    #0.5;
    // R10: outputs still hold the previous result before the edge
    check("R10", rx_byte, e_rx);
    compute_exp();
    @(posedge clk);
    if (ld) model_hi = req;
    @(negedge clk);
    check_all();
  endtask

  function automatic logic [LANES*SW-1:0] rx_rand(input bit clean);
    logic [LANES*SW-1:0] w;
    for (int n = 0; n < LANES; n++)
      w[n*SW +: SW] = clean ? dup(BW'($urandom)) : SW'($urandom);
    return w;
  endfunction

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [LANES*SW-1:0] w;
    void'($urandom(32'd1234));
    rst = 1; rate_req = 0; rate_load = 0; tx_byte = '1; ser_rx_word = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", ser_tx_word, 0);
    check("R1", rx_byte, 0);
    check("R1", rx_pair_err, 0);
    check("R1", fwd_clk_word, 0);
    check("R1", rate_hi, 0);
    e_rx = '0;
    rst = 0;
    model_hi = 0;

    // directed low-speed corners
    cycle('0, '0, 0, 0);
    cycle('1, '1, 0, 0);
    w = '0; w[0 +: SW] = dup(8'hA5); w[SW +: SW] = 16'h0002; // lane1 one pair split
    cycle(16'h3CA5, w, 0, 0);
    check("R6", rx_pair_err, 2'b10);
    check("R6", rx_byte[BW +: BW], 8'h00);

    // random low-speed
    for (int i = 0; i < 40; i++) cycle(16'($urandom), rx_rand($urandom_range(0, 1) == 1), 0, 0);

    // R9: request changes without load are ignored
    for (int i = 0; i < 5; i++) cycle(16'($urandom), rx_rand(1), 0, 1);
    check("R9", rate_hi, 0);

    // load high-speed: word at load edge still low-speed
    cycle(16'h1234, rx_rand(1), 1, 1);
    check("R9", rate_hi, 1);

    // high-speed: upper received bits ignored
    cycle(16'h00FF, 32'hFFFF_00AA, 0, 1);
    cycle(16'h00FF, 32'h0000_00AA, 0, 1);
    check("R5", rx_byte, 16'h00AA);
    for (int i = 0; i < 40; i++) cycle(16'($urandom), rx_rand(0), 0, $urandom_range(0, 1));

    // back to low-speed by load
    cycle(16'hBEEF, rx_rand(0), 1, 0);
    for (int i = 0; i < 10; i++) cycle(16'($urandom), rx_rand(0), 0, 1);

    // reset with high request loads high rate
    rst = 1; rate_req = 1; rate_load = 0;
    @(negedge clk); @(negedge clk);
    check("R1", rate_hi, 1);
    check("R1", ser_tx_word, 0);
    rst = 0; model_hi = 1; e_rx = '0;
    for (int i = 0; i < 10; i++) cycle(16'($urandom), rx_rand(0), 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule